// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block turns software interrupt requests, raised by processors against each other, into pending and active state that each destination processor can collect. A processor writes a trigger word. The block decodes three things from that word: a 4-bit interrupt ID, an 8-bit destination list and a 2-bit filter mode. It then marks the request pending for every destination the mode selects, provided that destination's interface enable is high. Pending state is stored per destination, per interrupt ID and per source processor. The same ID raised by two different processors therefore stays as two separate requests.

Each destination has its own acknowledge strobe. When a destination raises it, the block returns the chosen request as a 13-bit word in the same cycle. At the next clock edge it clears that pending bit and sets the matching active bit. Software later returns the same 13-bit word on the destination's end-of-interrupt port, which clears the active bit again. Arbitration against other interrupt classes is left to the surrounding logic, and so is the register bus.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset, no destination reports pending or active state, and an acknowledge returns ID 1023 with source 0.
- R2: A trigger is decoded from three fields of the trigger word: the ID from bits [3:0], the destination list from bits [23:16] and the filter mode from bits [25:24]. With mode 0, every destination whose list bit is set receives the request from the writing processor, and pend_irq shows it one cycle after the trigger.
- R3: With mode 1, the request goes to every destination except the writer.
- R4: With mode 2, the request goes only to the writer.
- R5: A trigger with mode 3 changes no pending state.
- R6: A destination whose if_enable bit is low during the trigger cycle never receives the request.
- R7: While ack_req is high, ack_word shows the chosen request in the same cycle: the ID in bits [9:0] and the source processor in bits [12:10]. At the following edge, that pending bit clears and the matching active bit sets.
- R8: The same ID pending from several sources is acknowledged once per source, lowest-numbered source first.
- R9: Among different pending IDs, the lowest ID is acknowledged first.
- R10: An acknowledge with nothing pending returns ID 1023 with source 0 and changes no state.
- R11: An end-of-interrupt word uses the same layout as ack_word. It clears the active bit of that ID and source at the next edge.
- R12: If a trigger sets the same bit that an acknowledge clears in that cycle, the bit ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger write strobe |
| trig_src | input | 3 | Number of the writing processor |
| trig_word | input | 32 | Trigger word |
| if_enable | input | 8 | Per-destination interface enable |
| ack_req | input | 8 | Per-destination acknowledge strobe |
| ack_word | output | 104 | Per-destination acknowledge result, 13 bits each; destination d uses bits [13d+12:13d] |
| eoi_valid | input | 8 | Per-destination end-of-interrupt strobe |
| eoi_word | input | 104 | Per-destination end-of-interrupt word, 13 bits each |
| pend_irq | output | 8 | Destination has at least one pending request |
| active_irq | output | 8 | Destination has at least one active request |

## Verification
The assertions take for granted that an end-of-interrupt word names a request that was acknowledged. They also take for granted that a trigger and an acknowledge on the same bit in one cycle resolve as R12 states. The checks that bits clear carry an exclusion for that collision, so they hold under it. The stimulus returns each acknowledged word unchanged on the end-of-interrupt port. It keeps the trigger, acknowledge and end-of-interrupt strobes in separate cycles, apart from one deliberate collision for R12. It drives if_enable only while no trigger is in flight.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int LIST_W  = 8;
  localparam int IDF_W   = 10;
  localparam int SRCF_W  = 3;
  localparam int ACK_W   = IDF_W + SRCF_W;
  localparam logic [IDF_W-1:0] NO_IRQ_ID = 10'd1023;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_NONE   = 2'd3
  } filt_e;

  // destinations selected by a filter mode, before the enable mask
  function automatic logic [LIST_W-1:0] sgi_targets(filt_e mode,
                                                    logic [LIST_W-1:0] list,
                                                    logic [SRCF_W-1:0] writer);
    logic [LIST_W-1:0] self_bit;
    self_bit = LIST_W'(1) << writer;
    case (mode)
      FLT_LIST:   return list;
      FLT_OTHERS: return ~self_bit;
      FLT_SELF:   return self_bit;
      default:    return '0;
    endcase
  endfunction

  function automatic logic [ACK_W-1:0] ack_pack(logic [SRCF_W-1:0] src,
                                                logic [IDF_W-1:0] id);
    return {src, id};
  endfunction
endpackage

// File: rtl/sgi_trig_decode.sv
module sgi_trig_decode #(
  parameter int NUM_CPU = 8,
  parameter int NUM_ID  = 16,
  localparam int SRC_W  = $clog2(NUM_CPU),
  localparam int ID_W   = $clog2(NUM_ID)
) (
  input  logic               trig_valid,
  input  logic [SRC_W-1:0]   trig_src,
  input  logic [31:0]        trig_word,
  input  logic [NUM_CPU-1:0] if_enable,
  output logic [NUM_CPU-1:0] dest_mask,
  output logic [ID_W-1:0]    set_id
);
  import sgi_pkg::*;

  logic [3:0]        f_id;
  logic [LIST_W-1:0] f_list;
  filt_e             f_mode;
  logic              id_ok;
  logic [LIST_W-1:0] sel;
  logic              unused_bits;

  assign f_id        = trig_word[3:0];
  assign f_list      = trig_word[23:16];
  assign f_mode      = filt_e'(trig_word[25:24]);
  assign unused_bits = ^{trig_word[31:26], trig_word[15:4]};
  assign id_ok       = 32'(f_id) < NUM_ID;
  assign sel         = sgi_targets(f_mode, f_list, SRCF_W'(trig_src));
  assign set_id      = f_id[ID_W-1:0];
  assign dest_mask   = (trig_valid && id_ok) ? (sel[NUM_CPU-1:0] & if_enable) : '0;
endmodule

// File: rtl/sgi_dest_slice.sv
module sgi_dest_slice #(
  parameter int NUM_CPU = 8,
  parameter int NUM_ID  = 16,
  localparam int SRC_W  = $clog2(NUM_CPU),
  localparam int ID_W   = $clog2(NUM_ID),
  localparam int SLOTS  = NUM_ID * NUM_CPU,
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_en,
  input  logic [ID_W-1:0]        set_id,
  input  logic [SRC_W-1:0]       set_src,
  input  logic                   ack_req,
  output logic [sgi_pkg::ACK_W-1:0] ack_word,
  input  logic                   eoi_valid,
  input  logic [sgi_pkg::ACK_W-1:0] eoi_word,
  output logic                   pend_any,
  output logic                   act_any
);
  import sgi_pkg::*;

  function automatic logic [IDX_W-1:0] slot_of(logic [ID_W-1:0] id, logic [SRC_W-1:0] src);
    return IDX_W'(int'(id) * NUM_CPU + int'(src));
  endfunction

  logic [SLOTS-1:0] pend_q, pend_d, act_q, act_d;
  logic             found;
  logic [IDX_W-1:0] pick_idx, set_idx, eoi_idx;
  logic             ack_hit, eoi_ok;
  logic [IDF_W-1:0] pick_id;
  logic [SRCF_W-1:0] pick_src;

  // lowest slot wins: lowest ID, then lowest source
  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        found    = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end

  assign pick_id  = IDF_W'(int'(pick_idx) / NUM_CPU);
  assign pick_src = SRCF_W'(int'(pick_idx) % NUM_CPU);
  assign ack_word = found ? ack_pack(pick_src, pick_id) : ack_pack('0, NO_IRQ_ID);
  assign ack_hit  = ack_req && found;
  assign set_idx  = slot_of(set_id, set_src);
  assign eoi_ok   = eoi_valid && (32'(eoi_word[IDF_W-1:0]) < NUM_ID)
                    && (32'(eoi_word[ACK_W-1:IDF_W]) < NUM_CPU);
  assign eoi_idx  = slot_of(eoi_word[ID_W-1:0], eoi_word[IDF_W +: SRC_W]);

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    if (ack_hit) pend_d[pick_idx] = 1'b0;
    if (set_en)  pend_d[set_idx]  = 1'b1;
    if (eoi_ok)  act_d[eoi_idx]   = 1'b0;
    if (ack_hit) act_d[pick_idx]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign pend_any = |pend_q;
  assign act_any  = |act_q;

  // R7
  ack_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit && !(set_en && set_idx == pick_idx) |=> !pend_q[$past(pick_idx)]);
  // R7
  ack_sets_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> act_q[$past(pick_idx)]);
  // R11
  eoi_clears_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_ok && !(ack_hit && pick_idx == eoi_idx) |=> !act_q[$past(eoi_idx)]);
  // R10
  empty_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && !pend_any |-> ack_word == {3'b000, 10'd1023});
  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> pend_q[$past(set_idx)]);
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
  parameter int NUM_CPU = 8,
  parameter int NUM_ID  = 16,
  localparam int SRC_W  = $clog2(NUM_CPU),
  localparam int ID_W   = $clog2(NUM_ID),
  localparam int AW     = sgi_pkg::ACK_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig_valid,
  input  logic [SRC_W-1:0]      trig_src,
  input  logic [31:0]           trig_word,
  input  logic [NUM_CPU-1:0]    if_enable,
  input  logic [NUM_CPU-1:0]    ack_req,
  output logic [NUM_CPU*AW-1:0] ack_word,
  input  logic [NUM_CPU-1:0]    eoi_valid,
  input  logic [NUM_CPU*AW-1:0] eoi_word,
  output logic [NUM_CPU-1:0]    pend_irq,
  output logic [NUM_CPU-1:0]    active_irq
);
  logic [NUM_CPU-1:0] dest_mask;
  logic [ID_W-1:0]    set_id;

  sgi_trig_decode #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID)) dec_i (
    .trig_valid(trig_valid),
    .trig_src  (trig_src),
    .trig_word (trig_word),
    .if_enable (if_enable),
    .dest_mask (dest_mask),
    .set_id    (set_id)
  );

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_dest
    sgi_dest_slice #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID)) slice_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (dest_mask[g]),
      .set_id   (set_id),
      .set_src  (trig_src),
      .ack_req  (ack_req[g]),
      .ack_word (ack_word[g*AW +: AW]),
      .eoi_valid(eoi_valid[g]),
      .eoi_word (eoi_word[g*AW +: AW]),
      .pend_any (pend_irq[g]),
      .act_any  (active_irq[g])
    );

    // R6
    enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_irq[g]) |-> $past(if_enable[g]));
  end

  // R5
  mode3_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && trig_word[25:24] == 2'd3 && ack_req == '0 |=> $stable(pend_irq));
endmodule

// File: tb/sgi_dispatch_tb_top.sv
module sgi_dispatch_tb_top;
  localparam int N = 8;
  localparam int NI = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_valid = 1'b0;
  logic [2:0] trig_src = '0;
  logic [31:0] trig_word = '0;
  logic [N-1:0] if_enable = '1;
  logic [N-1:0] ack_req = '0;
  logic [N*13-1:0] ack_word;
  logic [N-1:0] eoi_valid = '0;
  logic [N*13-1:0] eoi_word = '0;
  logic [N-1:0] pend_irq, active_irq;

  int checks = 0;
  int errors = 0;
  bit exp_p [N][NI][N];   // dest, id, src

  always #4 clk = ~clk;

  sgi_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_src(trig_src),
    .trig_word(trig_word), .if_enable(if_enable), .ack_req(ack_req),
    .ack_word(ack_word), .eoi_valid(eoi_valid), .eoi_word(eoi_word),
    .pend_irq(pend_irq), .active_irq(active_irq)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_pend();
    logic [N-1:0] r = '0;
    for (int d = 0; d < N; d++)
      for (int i = 0; i < NI; i++)
        for (int s = 0; s < N; s++)
          if (exp_p[d][i][s]) r[d] = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] exp_targets(int mode, logic [7:0] list, int w);
    case (mode)
      0: return list;
      1: return ~(8'h1 << w);
      2: return 8'h1 << w;
      default: return 8'h0;
    endcase
  endfunction

  task automatic trigger(int w, int mode, logic [7:0] list, int id, logic [7:0] en, string req);
    logic [7:0] t;
    @(negedge clk);
    if_enable = en;
    trig_src = 3'(w);
    trig_word = {6'b0, 2'(mode), list, 12'b0, 4'(id)};
    trig_valid = 1'b1;
    @(negedge clk);
    trig_valid = 1'b0;
    t = exp_targets(mode, list, w) & en;
    for (int d = 0; d < N; d++) if (t[d]) exp_p[d][id][w] = 1'b1;
    #1;
    chk(pend_irq == exp_pend(), req, int'(pend_irq), int'(exp_pend()));
  endtask

  // acknowledge one request for d, then return it via end-of-interrupt
  task automatic ack_one(int d);
    int ei = 1023, es = 0;
    logic [12:0] got;
    for (int i = NI - 1; i >= 0; i--)
      for (int s = N - 1; s >= 0; s--)
        if (exp_p[d][i][s]) begin ei = i; es = s; end
    @(negedge clk);
    ack_req[d] = 1'b1;
    #1;
    got = ack_word[d*13 +: 13];
    chk(got == {3'(es), 10'(ei)}, "R7 R8 R9 R10 ack value", int'(got), (es << 10) | ei);
    @(negedge clk);
    ack_req[d] = 1'b0;
    #1;
    if (ei != 1023) begin
      exp_p[d][ei][es] = 1'b0;
      chk(active_irq[d] == 1'b1, "R7 active set", int'(active_irq[d]), 1);
      chk(pend_irq == exp_pend(), "R7 pending cleared", int'(pend_irq), int'(exp_pend()));
      @(negedge clk);
      eoi_valid[d] = 1'b1;
      eoi_word[d*13 +: 13] = got;
      @(negedge clk);
      eoi_valid[d] = 1'b0;
      #1;
      chk(active_irq[d] == 1'b0, "R11 active cleared", int'(active_irq[d]), 0);
    end else begin
      chk(pend_irq == exp_pend() && active_irq == '0, "R10 no state change",
          int'({active_irq, pend_irq}), int'(exp_pend()));
    end
  endtask

  task automatic drain_all();
    for (int d = 0; d < N; d++) begin
      while (exp_pend()[d]) ack_one(d);
      ack_one(d);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    logic [12:0] w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(pend_irq == '0, "R1 pend after reset", int'(pend_irq), 0);
    chk(active_irq == '0, "R1 active after reset", int'(active_irq), 0);
    w0 = ack_word[12:0];
    chk(w0 == 13'd1023, "R1 idle ack word", int'(w0), 1023);

    // sweep: every writer x every mode x three list/enable patterns
    for (int w = 0; w < N; w++)
      for (int m = 0; m < 4; m++)
        for (int lp = 0; lp < 3; lp++) begin
          logic [7:0] list, en;
          list = (lp == 0) ? 8'hA5 : (lp == 1) ? 8'h3C : 8'hFF;
          en = (lp == 2) ? ~(8'h1 << ((w + lp) % N)) : 8'hFF;
          trigger(w, m, list, (w * 4 + m + lp) % NI, en,
                  m == 0 ? "R2 list mode" : m == 1 ? "R3 others mode" :
                  m == 2 ? "R4 self mode" : "R5 ignored mode");
          if (lp == 2) begin
            chk(pend_irq[(w + lp) % N] == 1'b0, "R6 disabled dest",
                int'(pend_irq[(w + lp) % N]), 0);
          end
          drain_all();
        end

    // R8: same ID from sources 5 and 2 to destination 4
    trigger(5, 0, 8'h10, 7, 8'hFF, "R8 setup");
    trigger(2, 0, 8'h10, 7, 8'hFF, "R8 setup");
    trigger(6, 0, 8'h10, 3, 8'hFF, "R9 setup");
    drain_all();

    // accumulated mix, then drain in priority order (R8, R9)
    lcg = 32'h1234_5678;
    for (int k = 0; k < 40; k++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      trigger(int'(lcg[18:16]), int'(lcg[21:20]) % 3, lcg[31:24], int'(lcg[11:8]),
              8'hFF, "R2 R3 R4 mixed");
    end
    drain_all();

    // R12: trigger and acknowledge of the same bit in one cycle
    trigger(1, 0, 8'h08, 9, 8'hFF, "R12 setup");
    @(negedge clk);
    trig_src = 3'd1;
    trig_word = {6'b0, 2'd0, 8'h08, 12'b0, 4'd9};
    trig_valid = 1'b1;
    ack_req[3] = 1'b1;
    @(negedge clk);
    trig_valid = 1'b0;
    ack_req[3] = 1'b0;
    #1;
    chk(pend_irq[3] == 1'b1, "R12 set wins", int'(pend_irq[3]), 1);
    chk(active_irq[3] == 1'b1, "R12 active set", int'(active_irq[3]), 1);
    @(negedge clk);
    eoi_valid[3] = 1'b1;
    eoi_word[3*13 +: 13] = {3'd1, 10'd9};
    @(negedge clk);
    eoi_valid[3] = 1'b0;
    drain_all();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule